// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block resolves read-after-write conflicts in a five-stage integer pipeline (fetch, decode/read, execute, memory, write-back). It takes the register fields of the instruction now in decode (two source numbers, a destination number, a write enable and a load flag). It carries those fields down its own three-stage copy of the control pipeline, so at each cycle it knows what sits in execute, memory and write-back. From that copy it drives one bypass select per ALU operand, so that a result not yet written back reaches the consuming instruction in execute.

A result still held after the memory stage is the only thing a load can supply, so a load followed at once by an instruction that reads its destination causes a single-cycle interlock. During that cycle the program counter and the fetch/decode register are frozen, and a no-op is placed into the decode/execute register. The register file is assumed to write early in the cycle and read late, so a producer in write-back needs no bypass to a reader in decode. Operand data, the ALU, the memories and the register file stay outside the block.

Top module: `fwd_stall_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both operand selects are 00, load_stall and drex_clr are 0, and pc_en and ifdr_en are 1.
- R2: When a source of the instruction in execute equals the destination held in the execute/memory stage, with write enable set and a non-zero number, that operand's select is 10 (bypass from execute/memory).
- R3: When only the memory/write-back stage holds a matching destination with write enable set and a non-zero number, the select is 01 (bypass from memory/write-back).
- R4: When both later stages match the same source, the select is 10: the younger result wins.
- R5: Register 0 never yields a bypass select other than 00 and never causes an interlock.
- R6: A stage whose write enable is clear never matches, whatever its destination number.
- R7: When the instruction in execute is a load with write enable set and a non-zero destination equal to either source of the decode instruction, load_stall and drex_clr are 1 and pc_en and ifdr_en are 0 for exactly one cycle.
- R8: The instruction placed in execute by an interlock is a no-op: it neither matches a later consumer nor causes an interlock.
- R9: A producer three or more instructions ahead of the consumer gives select 00 (the register file already holds its value).
- R10: The two operand selects are decided independently, so each may take a different value in the same cycle.
- R11: An instruction in execute that is not a load never causes an interlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_rs1 | input | 5 | First source register of the decode instruction |
| dr_rs2 | input | 5 | Second source register of the decode instruction |
| dr_rd | input | 5 | Destination register of the decode instruction |
| dr_wr_en | input | 1 | Decode instruction writes its destination |
| dr_is_load | input | 1 | Decode instruction is a load |
| op_a_sel | output | 2 | First ALU operand select: 00 register file, 01 memory/write-back, 10 execute/memory |
| op_b_sel | output | 2 | Second ALU operand select, same encoding |
| load_stall | output | 1 | Load-use interlock active this cycle |
| pc_en | output | 1 | Program counter may advance |
| ifdr_en | output | 1 | Fetch/decode register may load |
| drex_clr | output | 1 | Replace the decode/execute contents with a no-op |

## Verification
The assertions take for granted that the surrounding pipeline honours the interlock: while load_stall is high the decode fields stay unchanged, because the fetch/decode register is frozen. The bench enforces this by re-presenting the same instruction every cycle until the interlock clears, both in its directed sequences and in its random stream. Random register numbers are drawn from a small range including register 0, so matches in both later stages, double matches and load-use pairs occur often.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned N_SRC  = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_EXM = 2'b10
  } opsel_e;

  typedef struct packed {
    logic [N_SRC-1:0][REG_AW-1:0] src;
    logic [REG_AW-1:0]            rd;
    logic                         we;
    logic                         ld;
  } ctl_t;

  typedef struct packed {
    logic [REG_AW-1:0] rd;
    logic              we;
    logic              ld;
  } dst_t;

  localparam ctl_t CTL_NOP = '0;
endpackage

// File: rtl/hz_ctrl_pipe.sv
module hz_ctrl_pipe
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              dr_ctl,
  input  logic              bubble,
  output ctl_t              ex_ctl,
  output dst_t              mem_dst,
  output logic [REG_AW-1:0] wb_rd,
  output logic              wb_we
);
  ctl_t              ex_d, ex_q;
  dst_t              mem_d, mem_q;
  logic [REG_AW-1:0] wb_rd_d, wb_rd_q;
  logic              wb_we_d, wb_we_q;

  always_comb begin
    ex_d    = bubble ? CTL_NOP : dr_ctl;
    mem_d   = '{rd: ex_q.rd, we: ex_q.we, ld: ex_q.ld};
    wb_rd_d = mem_q.rd;
    wb_we_d = mem_q.we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q    <= CTL_NOP;
      mem_q   <= '0;
      wb_rd_q <= '0;
      wb_we_q <= 1'b0;
    end else begin
      ex_q    <= ex_d;
      mem_q   <= mem_d;
      wb_rd_q <= wb_rd_d;
      wb_we_q <= wb_we_d;
    end
  end

  assign ex_ctl  = ex_q;
  assign mem_dst = mem_q;
  assign wb_rd   = wb_rd_q;
  assign wb_we   = wb_we_q;
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
(
  input  logic [N_SRC-1:0][REG_AW-1:0] ex_src,
  input  logic [REG_AW-1:0]            mem_rd,
  input  logic                         mem_we,
  input  logic [REG_AW-1:0]            wb_rd,
  input  logic                         wb_we,
  output logic [N_SRC-1:0][1:0]        sel
);
  logic mem_live, wb_live;

  assign mem_live = mem_we && (mem_rd != '0);
  assign wb_live  = wb_we  && (wb_rd  != '0);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic hit_mem, hit_wb;
    opsel_e s;
    assign hit_mem = mem_live && (mem_rd == ex_src[i]);
    assign hit_wb  = wb_live  && (wb_rd  == ex_src[i]);
    always_comb begin
      if (hit_mem)     s = SEL_EXM;
      else if (hit_wb) s = SEL_WB;
      else             s = SEL_RF;
    end
    assign sel[i] = s;
  end
endmodule

// File: rtl/hz_load_interlock.sv
module hz_load_interlock
  import hz_pkg::*;
(
  input  logic [N_SRC-1:0][REG_AW-1:0] dr_src,
  input  logic [REG_AW-1:0]            ex_rd,
  input  logic                         ex_we,
  input  logic                         ex_ld,
  output logic                         stall
);
  logic [N_SRC-1:0] hit;
  logic             ld_live;

  assign ld_live = ex_ld && ex_we && (ex_rd != '0);

  for (genvar i = 0; i < N_SRC; i++) begin : g_hit
    assign hit[i] = (dr_src[i] == ex_rd);
  end

  assign stall = ld_live && (|hit);
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] dr_rs1,
  input  logic [REG_AW-1:0] dr_rs2,
  input  logic [REG_AW-1:0] dr_rd,
  input  logic              dr_wr_en,
  input  logic              dr_is_load,
  output logic [1:0]        op_a_sel,
  output logic [1:0]        op_b_sel,
  output logic              load_stall,
  output logic              pc_en,
  output logic              ifdr_en,
  output logic              drex_clr
);
  ctl_t                  dr_ctl, ex_ctl;
  dst_t                  mem_dst;
  logic [REG_AW-1:0]     wb_rd;
  logic                  wb_we;
  logic                  stall;
  logic [N_SRC-1:0][1:0] sel;
  logic                  ex_we, mem_ld;

  always_comb begin
    dr_ctl        = CTL_NOP;
    dr_ctl.src[0] = dr_rs1;
    dr_ctl.src[1] = dr_rs2;
    dr_ctl.rd     = dr_rd;
    dr_ctl.we     = dr_wr_en;
    dr_ctl.ld     = dr_is_load;
  end

  hz_ctrl_pipe u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .dr_ctl  (dr_ctl),
    .bubble  (stall),
    .ex_ctl  (ex_ctl),
    .mem_dst (mem_dst),
    .wb_rd   (wb_rd),
    .wb_we   (wb_we)
  );

  hz_fwd_sel u_fwd (
    .ex_src (ex_ctl.src),
    .mem_rd (mem_dst.rd),
    .mem_we (mem_dst.we),
    .wb_rd  (wb_rd),
    .wb_we  (wb_we),
    .sel    (sel)
  );

  hz_load_interlock u_lock (
    .dr_src (dr_ctl.src),
    .ex_rd  (ex_ctl.rd),
    .ex_we  (ex_ctl.we),
    .ex_ld  (ex_ctl.ld),
    .stall  (stall)
  );

  assign ex_we      = ex_ctl.we;
  assign mem_ld     = mem_dst.ld;
  assign op_a_sel   = sel[0];
  assign op_b_sel   = sel[1];
  assign load_stall = stall;
  assign drex_clr   = stall;
  assign pc_en      = ~stall;
  assign ifdr_en    = ~stall;
endmodule

// File: rtl/fwd_stall_chk.sv
module fwd_stall_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] dr_rs1,
  input logic [4:0] dr_rs2,
  input logic [1:0] op_a_sel,
  input logic [1:0] op_b_sel,
  input logic       load_stall,
  input logic       drex_clr,
  input logic       ex_we,
  input logic       mem_ld
);
  AST_SEL_A_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) op_a_sel != 2'b11); // R2
  AST_SEL_B_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) op_b_sel != 2'b11); // R10
  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) load_stall |=> !load_stall); // R7
  AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) drex_clr |=> !ex_we); // R8
  AST_X0_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rs1 == 5'd0 && dr_rs2 == 5'd0) |-> !load_stall); // R5
  AST_NO_LOAD_EXM_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ld |-> (op_a_sel != 2'b10 && op_b_sel != 2'b10)); // R7
endmodule

bind fwd_stall_unit fwd_stall_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dr_rs1     (dr_rs1),
  .dr_rs2     (dr_rs2),
  .op_a_sel   (op_a_sel),
  .op_b_sel   (op_b_sel),
  .load_stall (load_stall),
  .drex_clr   (drex_clr),
  .ex_we      (ex_we),
  .mem_ld     (mem_ld)
);

// File: tb/test_fwd_stall_unit.sv
module test_fwd_stall_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] dr_rs1, dr_rs2, dr_rd;
  logic       dr_wr_en, dr_is_load;
  logic [1:0] op_a_sel, op_b_sel;
  logic       load_stall, pc_en, ifdr_en, drex_clr;

  int total = 0;
  int bad   = 0;

  typedef struct packed {
    logic [4:0] s1, s2, rd;
    logic       we, ld, bub;
  } bins_t;

  bins_t m_ex = '0, m_mem = '0, m_wb = '0;

  always #5 clk = ~clk;

  fwd_stall_unit i_fwd_stall_unit (
    .clk(clk), .rst_n(rst_n), .dr_rs1(dr_rs1), .dr_rs2(dr_rs2), .dr_rd(dr_rd),
    .dr_wr_en(dr_wr_en), .dr_is_load(dr_is_load), .op_a_sel(op_a_sel),
    .op_b_sel(op_b_sel), .load_stall(load_stall), .pc_en(pc_en),
    .ifdr_en(ifdr_en), .drex_clr(drex_clr)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [4:0] src);
    if (m_mem.we && m_mem.rd != 0 && m_mem.rd == src) return 2'b10;
    if (m_wb.we && m_wb.rd != 0 && m_wb.rd == src)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [4:0] src);
    logic hm, hw;
    hm = m_mem.we && m_mem.rd != 0 && m_mem.rd == src;
    hw = m_wb.we && m_wb.rd != 0 && m_wb.rd == src;
    if (src == 0)                                  return "R5";
    if (m_mem.bub)                                 return "R8";
    if (hm && hw)                                  return "R4";
    if (hm)                                        return "R2";
    if (hw)                                        return "R3";
    if (m_mem.rd == src || m_wb.rd == src)         return "R6";
    return "R9";
  endfunction

  // Present one instruction in decode; hold it while the interlock is expected.
  task automatic step(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                      input logic w, input logic l);
    logic st;
    logic [1:0] ea, eb;
    bins_t cur;
    do begin
      @(negedge clk);
      dr_rs1 = a; dr_rs2 = b; dr_rd = d; dr_wr_en = w; dr_is_load = l;
      #1;
      ea = exp_sel(m_ex.s1);
      eb = exp_sel(m_ex.s2);
      st = m_ex.we && m_ex.ld && m_ex.rd != 0 && (m_ex.rd == a || m_ex.rd == b);
      chk(sel_tag(m_ex.s1), {2'b00, op_a_sel}, {2'b00, ea});
      chk(sel_tag(m_ex.s2), {2'b00, op_b_sel}, {2'b00, eb});
      if (ea != eb) chk("R10", {op_a_sel, op_b_sel}, {ea, eb});
      if (st) chk("R7", {load_stall, drex_clr, pc_en, ifdr_en}, 4'b1100);
      else if (m_ex.bub) chk("R8", {load_stall, drex_clr, pc_en, ifdr_en}, 4'b0011);
      else chk("R11", {load_stall, drex_clr, pc_en, ifdr_en}, 4'b0011);
      @(posedge clk);
      cur = '{s1: a, s2: b, rd: d, we: w, ld: l, bub: 1'b0};
      m_wb  = m_mem;
      m_mem = m_ex;
      m_ex  = st ? bins_t'{bub: 1'b1, default: '0} : cur;
    end while (st);
  endtask

  task automatic nop();
    step(5'd0, 5'd0, 5'd0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL R1 watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    rst_n = 1'b0;
    dr_rs1 = 0; dr_rs2 = 0; dr_rd = 0; dr_wr_en = 0; dr_is_load = 0;
    seed_v = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {op_a_sel, op_b_sel}, 4'h0);
    chk("R1", {load_stall, drex_clr, pc_en, ifdr_en}, 4'b0011);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", {op_a_sel, op_b_sel}, 4'h0);
    chk("R1", {load_stall, drex_clr, pc_en, ifdr_en}, 4'b0011);

    // R2: back-to-back producer/consumer
    step(0, 0, 5'd1, 1, 0); step(5'd1, 5'd0, 5'd2, 1, 0); nop(); nop();
    // R3: one instruction between
    step(0, 0, 5'd3, 1, 0); nop(); step(5'd0, 5'd3, 5'd4, 1, 0); nop(); nop();
    // R4: two producers of the same register
    step(0, 0, 5'd5, 1, 0); step(0, 0, 5'd5, 1, 0); step(5'd5, 5'd5, 0, 0, 0); nop(); nop();
    // R5: register 0 producer and load
    step(0, 0, 5'd0, 1, 1); step(5'd0, 5'd0, 5'd6, 1, 0); nop(); nop();
    // R6: producer with write enable clear
    step(0, 0, 5'd7, 0, 1); step(5'd7, 5'd7, 0, 0, 0); nop(); nop();
    // R9: distance of three
    step(0, 0, 5'd8, 1, 0); nop(); nop(); step(5'd8, 5'd8, 0, 0, 0); nop(); nop();
    // R10: each operand from a different stage
    step(0, 0, 5'd9, 1, 0); step(0, 0, 5'd10, 1, 0); step(5'd10, 5'd9, 0, 0, 0); nop(); nop();
    // R7/R8: load-use then the bubble travels on
    step(0, 0, 5'd11, 1, 1); step(5'd11, 5'd0, 5'd12, 1, 0); step(5'd12, 5'd11, 0, 0, 0); nop(); nop();
    // R11: non-load producer right ahead
    step(0, 0, 5'd13, 1, 0); step(5'd13, 5'd13, 0, 0, 0); nop(); nop();

    for (int n = 0; n < 3000; n++) begin
      step(5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4),
           ($urandom % 4) != 0, ($urandom % 3) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule